// File: doc/BRIEF.md
# Scrambled One-Bit Waveform DAC

This block plays back one channel of a stored spike waveform as a single-bit, density-modulated stream. That stream is meant to drive an external RC low-pass filter. A small synchronous ROM holds one cycle of the waveform. Each entry is an unsigned 12-bit value, and full scale is the top code. A sequencer holds a reference value that stays constant over each modulation period of 4096 clocks. Each stored sample stays in force for a fixed number of periods (2^SUB_LOG, default four) before the sequencer advances to the next address. When the last address is done, the sequencer returns to address zero.

Two ordering modes turn the reference into bits:
- **Accumulator mode:** a first-order accumulate-and-carry modulator.
- **Scrambled mode:** the reference is compared with the bit-reversed period count. This breaks the high time into short pulses spread evenly through the period.

Both modes give exactly the same number of ones per period. The ramp option makes the reference walk in equal steps from the current sample toward the next one, one step per period. The filtered output then follows a straight line between sample points instead of a staircase.

The ROM is filled through a write port while the generator is idle. Raising the enable starts playback from the first entry.

Top module: `spike_pdm_dac`

## Requirements
- R1: During and right after reset, dac_bit is 0.
- R2: While run_en is low, dac_bit is 0 from the next clock on. The next rise of run_en restarts playback at ROM address 0 and substep 0, with the period count at 0 and the modulator accumulator cleared.
- R3: Periods are counted from the first rising edge at which run_en is sampled high. Each period is 4096 clocks, and the result of each edge appears on dac_bit one clock later. Over every such period, the number of ones on dac_bit equals the reference held for that period, in both ordering modes.
- R4: With scramble_en = 0, a 12-bit accumulator is cleared at start. On every clock the reference is added to it, the 13th (carry) bit of the sum becomes the next dac_bit, and the low 12 bits are kept.
- R5: With scramble_en = 1, dac_bit is 1 exactly when the 12-bit period count, with its bit order reversed (bit 0 becomes the most significant bit), is less than the reference.
- R6: Each ROM entry sets the reference for 2^SUB_LOG consecutive periods. The address then increases by one. After the last entry it wraps to entry 0. By default the ROM has 64 entries of 12 bits.
- R7: With ramp_en = 1, substep k (0-based) of a sample uses the reference floor(cur + k*(next - cur)/2^SUB_LOG). Here next is the following entry, and the entry after the last one is entry 0. With ramp_en = 0, every substep uses cur.
- R8: When load_we is high on a clock edge, load_data is written to load_addr. Values written while run_en is low, at least two clocks before run_en rises, are used by the following run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | High to play back; low to idle and restart |
| scramble_en | input | 1 | Selects bit-reversed ordering instead of the accumulator |
| ramp_en | input | 1 | Enables the linear walk between samples |
| load_we | input | 1 | ROM write strobe |
| load_addr | input | ADDR_W | ROM write address |
| load_data | input | DATA_W | ROM write data |
| dac_bit | output | 1 | Registered one-bit output stream |

## Verification
The bench loads the extreme codes 0 and 4095 and checks that one period gives no ones at all or 4095 ones. A modulator that drops the carry or that saturates its accumulator would miss those counts.

The bench compares dac_bit with an exact bit-by-bit model in both orders. This catches an unreversed or misreversed count, which keeps the duty correct but bunches the pulses, and also an accumulator that is not cleared on restart.

For the ramp, the bench includes a falling slope, where flooring a negative step matters, and the interpolation from the last entry back to entry 0. A wrong wrap address or a truncating divide would shift those references by one code or more.

// File: rtl/spdac_pkg.sv
package spdac_pkg;
  typedef enum logic {
    ORDER_ACCUM    = 1'b0,
    ORDER_SCRAMBLE = 1'b1
  } order_e;
endpackage

// File: rtl/spdac_period_timer.sv
module spdac_period_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  output logic [W-1:0] cnt,
  output logic         last
);
  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign last = run && (cnt == '1);
endmodule

// File: rtl/spdac_wave_rom.sv
module spdac_wave_rom #(
  parameter int AW = 6,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spdac_ref_seq.sv
module spdac_ref_seq #(
  parameter int AW      = 6,
  parameter int DW      = 12,
  parameter int SUB_LOG = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          ramp,
  input  logic          last,
  input  logic [DW-1:0] rom_q,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] ref_val
);
  localparam int SUBS  = 1 << SUB_LOG;
  localparam int SUB_W = (SUB_LOG > 0) ? SUB_LOG : 1;
  localparam int ACC_W = DW + SUB_LOG + 2;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUBS - 1);
  localparam logic signed [ACC_W-1:0] TOPV = ACC_W'((1 << DW) - 1);

  logic [AW-1:0]           addr;
  logic [SUB_W-1:0]        sub;
  logic [DW-1:0]           cur_s;
  logic signed [ACC_W-1:0] acc;
  logic signed [DW+1:0]    diff;
  logic signed [ACC_W-1:0] acc_nx;
  logic signed [ACC_W-1:0] lin;
  logic [DW-1:0]           lin_sat;

  // next entry is read continuously; entry 0 while idle
  assign rd_addr = run ? AW'(addr + 1'b1) : '0;

  assign diff   = $signed({2'b00, rom_q}) - $signed({2'b00, cur_s});
  assign acc_nx = acc + ACC_W'(diff);
  assign lin    = acc_nx >>> SUB_LOG;

  always_comb begin
    if (lin[ACC_W-1])   lin_sat = '0;
    else if (lin > TOPV) lin_sat = '1;
    else                lin_sat = lin[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr    <= '0;
      sub     <= '0;
      cur_s   <= '0;
      acc     <= '0;
      ref_val <= '0;
    end else if (!run) begin
      addr    <= '0;
      sub     <= '0;
      cur_s   <= rom_q;
      acc     <= ACC_W'(rom_q) << SUB_LOG;
      ref_val <= rom_q;
    end else if (last) begin
      if (sub == SUB_LAST) begin
        addr    <= AW'(addr + 1'b1);
        sub     <= '0;
        cur_s   <= rom_q;
        acc     <= ACC_W'(rom_q) << SUB_LOG;
        ref_val <= rom_q;
      end else begin
        sub     <= SUB_W'(sub + 1'b1);
        acc     <= acc_nx;
        ref_val <= ramp ? lin_sat : cur_s;
      end
    end
  end

  AST_REF_HELD: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && !$past(last)) |-> $stable(ref_val)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && addr != $past(addr)) |-> addr == AW'($past(addr) + 1'b1)); // R6
  AST_SUB0_REF: assert property (@(posedge clk) disable iff (rst)
    (sub == '0) |-> ref_val == cur_s); // R7
endmodule

// File: rtl/spdac_bit_mod.sv
module spdac_bit_mod
  import spdac_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  order_e        order,
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] ref_val,
  output logic          bit_q
);
  logic [DW-1:0] rev;
  logic [DW-1:0] sd_acc;
  logic [DW:0]   sd_sum;
  logic          o;
  logic [DW:0]   ones_cnt;

  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign rev[i] = cnt[DW-1-i];
  end

  assign sd_sum = {1'b0, sd_acc} + {1'b0, ref_val};
  assign o = (order == ORDER_SCRAMBLE) ? (rev < ref_val) : sd_sum[DW];

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sd_acc <= '0;
      bit_q  <= 1'b0;
    end else begin
      sd_acc <= sd_sum[DW-1:0];
      bit_q  <= o;
    end
  end

  // ones counted over the current period, for the duty check only
  always_ff @(posedge clk) begin
    if (rst || !run || cnt == '1) ones_cnt <= '0;
    else                          ones_cnt <= ones_cnt + (DW+1)'(o);
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> !bit_q); // R2
  AST_PERIOD_DUTY: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == '1) |-> (ones_cnt + (DW+1)'(o)) == {1'b0, ref_val}); // R3
endmodule

// File: rtl/spike_pdm_dac.sv
module spike_pdm_dac
  import spdac_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 12,
  parameter int SUB_LOG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              scramble_en,
  input  logic              ramp_en,
  input  logic              load_we,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic              dac_bit
);
  logic [DATA_W-1:0] cnt;
  logic              last;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rom_q;
  logic [DATA_W-1:0] ref_val;
  order_e            order;

  assign order = scramble_en ? ORDER_SCRAMBLE : ORDER_ACCUM;

  spdac_period_timer #(.W(DATA_W)) u_timer (
    .clk(clk), .rst(rst), .run(run_en), .cnt(cnt), .last(last)
  );

  spdac_wave_rom #(.AW(ADDR_W), .DW(DATA_W)) u_rom (
    .clk(clk), .we(load_we), .waddr(load_addr), .wdata(load_data),
    .raddr(rd_addr), .rdata(rom_q)
  );

  spdac_ref_seq #(.AW(ADDR_W), .DW(DATA_W), .SUB_LOG(SUB_LOG)) u_seq (
    .clk(clk), .rst(rst), .run(run_en), .ramp(ramp_en), .last(last),
    .rom_q(rom_q), .rd_addr(rd_addr), .ref_val(ref_val)
  );

  spdac_bit_mod #(.DW(DATA_W)) u_mod (
    .clk(clk), .rst(rst), .run(run_en), .order(order), .cnt(cnt),
    .ref_val(ref_val), .bit_q(dac_bit)
  );
endmodule

// File: tb/sim_spike_pdm_dac.sv
module sim_spike_pdm_dac;
  localparam int AW = 2;
  localparam int DW = 12;
  localparam int SL = 2;
  localparam int NE = 1 << AW;
  localparam int SUBS = 1 << SL;
  localparam int PER = 1 << DW;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0, scramble_en = 1'b0, ramp_en = 1'b0;
  logic load_we = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [DW-1:0] load_data = '0;
  logic dac_bit;

  int n_chk = 0, n_fail = 0;
  int bm [NE];

  always #10 clk = ~clk;

  spike_pdm_dac #(.ADDR_W(AW), .DATA_W(DW), .SUB_LOG(SL)) u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .scramble_en(scramble_en),
    .ramp_en(ramp_en), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .dac_bit(dac_bit)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int bitrev(input int c);
    int r = 0;
    for (int i = 0; i < DW; i++) if (c[i]) r |= 1 << (DW - 1 - i);
    return r;
  endfunction

  // R6 R7: reference for period p of a run
  function automatic int exp_ref(input int p, input bit lin);
    int s = (p / SUBS) % NE;
    int k = p % SUBS;
    int cur = bm[s];
    int nxt = bm[(s + 1) % NE];
    if (!lin) return cur;
    return (cur * SUBS + k * (nxt - cur)) / SUBS;
  endfunction

  task automatic load(input int a, input int d);
    @(negedge clk);
    load_we = 1'b1; load_addr = AW'(a); load_data = DW'(d);
    bm[a] = d;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic play(input int nper, input bit scr, input bit lin);
    int acc = 0;
    repeat (4) @(negedge clk);
    scramble_en = scr; ramp_en = lin; run_en = 1'b1;
    for (int p = 0; p < nper; p++) begin
      int r = exp_ref(p, lin);
      int ones = 0, miss = 0;
      for (int c = 0; c < PER; c++) begin
        int eb;
        int sum = acc + r;
        if (scr) eb = (bitrev(c) < r) ? 1 : 0;
        else     eb = sum >> DW;
        acc = sum % PER;
        @(negedge clk);
        ones += int'(dac_bit);
        if (int'(dac_bit) != eb) miss++;
      end
      chk(ones == r, "R3 ones per period", ones, r);
      chk(miss == 0, scr ? "R5 scrambled pattern" : "R4 accumulator pattern", miss, 0);
    end
    run_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(dac_bit == 1'b0, "R2 idle output", int'(dac_bit), 0);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual %0d expected %0d", LIMIT, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed = $urandom(32'd4711);
    repeat (4) @(negedge clk);
    chk(dac_bit == 1'b0, "R1 reset output", int'(dac_bit), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(dac_bit == 1'b0, "R1 after reset", int'(dac_bit), 0);
    // R8 directed extremes and a falling slope
    load(0, 0); load(1, 4095); load(2, 2048); load(3, 1000);
    play(5, 1'b0, 1'b0);            // R4 full and empty codes
    play(17, 1'b1, 1'b1);           // R5 R7 ramp, wrap last->0 (R6)
    // R2: drop enable mid-period, then restart from entry 0
    @(negedge clk); run_en = 1'b1;
    repeat (300) @(negedge clk);
    run_en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(dac_bit == 1'b0, "R2 abort quiet", int'(dac_bit), 0);
    // random contents, R8 reload
    for (int i = 0; i < NE; i++) load(i, int'($urandom % PER));
    play(6, 1'b0, 1'b1);            // R7 ramp with accumulator order
    play(3, 1'b1, 1'b0);            // R5 steps without ramp
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule